// File: doc/BRIEF.md
# Common Scan Register with Drive-Level Select

This block holds the scan state of a row (common) driver for a passive-matrix LCD. A chain of stages, 240 by default, carries the first-line marker bit from stage to stage, one position per falling edge of the line clock. A direction input picks which end of the chain the marker enters and which way it travels. A duty input picks the chain's shape. In full mode it is one chain. In split mode it becomes two half-length chains that scan the upper and lower halves of the panel at the same time.

Each stage drives a small selector. The selector combines the stage bit with the AC phase input and the active-low blanking input, and produces a 2-bit code for one of four bias levels. The analog switches that follow use this code. The block runs on a system clock. The line clock is a level input in the same clock domain, and the block detects its falling edge by comparing it with the value it had one cycle earlier. When the chip runs as a slave of another driver, the system ties the duty input high and feeds the marker from the external timing source.

Top module: `commonScanDriver`

## Requirements
- R1: The stages change only in a system-clock cycle where the line clock was 1 in the previous cycle and is 0 now. In every other cycle all stages keep their values, whatever the marker, direction and duty inputs do.
- R2: With fullDuty=1 and shiftDir=1, each line-clock fall loads the marker into stage 240, and every stage k below 240 takes the previous value of stage k+1.
- R3: With fullDuty=1 and shiftDir=0, each fall loads the marker into stage 1, and every stage k above 1 takes the previous value of stage k-1.
- R4: With fullDuty=0 and shiftDir=1, each fall loads the marker into both stage 120 and stage 240. Within stages 1..120, and within stages 121..240, each stage takes the previous value of the stage one above it.
- R5: With fullDuty=0 and shiftDir=0, each fall loads the marker into both stage 1 and stage 121. Within stages 1..120, and within stages 121..240, each stage takes the previous value of the stage one below it.
- R6: With dispOffN=1, the code for stage k is chosen from the stage bit and acPhase as follows: bit 1 with acPhase 1 gives 2'b11 (V2); bit 0 with acPhase 1 gives 2'b01 (V6); bit 1 with acPhase 0 gives 2'b00 (V1); bit 0 with acPhase 0 gives 2'b10 (V5). The code for stage k sits at levelCodes[2k-1:2k-2].
- R7: While dispOffN=0, every code is 2'b00 (V1), whatever the stage bits and acPhase. The stages keep shifting while blanked, and this is visible once dispOffN returns to 1.
- R8: Reset (rstN=0) clears every stage to 0, so that just after reset all codes read 2'b10 with acPhase=0 and 2'b01 with acPhase=1. A line clock that is low when reset is released does not count as a fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineClk | input | 1 | Line clock level; its falling edge advances the scan |
| marker | input | 1 | First-line marker bit shifted into the entry stage(s) |
| shiftDir | input | 1 | 1: scan toward stage 1; 0: scan toward the last stage |
| fullDuty | input | 1 | 1: single full-length chain; 0: two half chains in parallel |
| acPhase | input | 1 | AC alternation phase of the drive waveform |
| dispOffN | input | 1 | Active-low blanking; forces every output to V1 |
| levelCodes | output | 2*NUM_STAGES | Per-stage level code, stage k at bits [2k-1:2k-2] |

## Verification
Directed walks send a single marker, and then a short multi-bit pattern, through each of the four combinations of direction and duty. A wrong entry stage, a missing split at the half boundary, or a reversed direction moves bits to the wrong stages, so each of these faults shows up in a different group of codes. Hold cycles change the marker, direction and duty inputs without a line-clock fall, which separates edge-qualified shifting from level-sensitive shifting. Long random runs mix all inputs, including blanking in the middle of a scan and duty changes in the middle of a frame, and compare the full 480-bit output each cycle with a bench model. The reset checks cover both AC phases, which separates the V5 and V6 codes.

// File: rtl/commonScanPkg.sv
package commonScanPkg;

  typedef enum logic [1:0] {
    LVL_V1 = 2'b00,
    LVL_V6 = 2'b01,
    LVL_V5 = 2'b10,
    LVL_V2 = 2'b11
  } level_e;

  // Strobes from the control module to the shift datapath
  typedef struct packed {
    logic shiftEn;      // one-cycle pulse on a line-clock fall
    logic splitMode;    // two half chains in parallel
    logic towardFirst;  // scan toward stage 1
    logic markerIn;     // bit entering the chain(s)
  } scanStrobe_t;

endpackage

// File: rtl/scanControl.sv
module scanControl
  import commonScanPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineClk,
  input  logic        marker,
  input  logic        shiftDir,
  input  logic        fullDuty,
  output scanStrobe_t strobe
);

  logic lineQ;

  // A low line clock at reset release must not look like a fall (R8)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lineQ <= 1'b0;
    else       lineQ <= lineClk;
  end

  always_comb begin
    strobe.shiftEn     = lineQ & ~lineClk;
    strobe.splitMode   = ~fullDuty;
    strobe.towardFirst = shiftDir;
    strobe.markerIn    = marker;
  end

  // R1: one fall gives exactly one shift pulse
  p_single_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftEn |=> !strobe.shiftEn);

endmodule

// File: rtl/scanShiftReg.sv
module scanShiftReg
  import commonScanPkg::*;
#(
  parameter int NUM_STAGES = 240
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  scanStrobe_t           strobe,
  output logic [NUM_STAGES-1:0] stages
);

  localparam int HALF = NUM_STAGES / 2;

  logic [NUM_STAGES-1:0] nextStages;

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
    logic downSrc;
    logic upSrc;

    if (g == NUM_STAGES - 1) begin : g_topEnd
      assign downSrc = strobe.markerIn;
    end else if (g == HALF - 1) begin : g_lowerTop
      assign downSrc = strobe.splitMode ? strobe.markerIn : stages[g+1];
    end else begin : g_downMid
      assign downSrc = stages[g+1];
    end

    if (g == 0) begin : g_bottomEnd
      assign upSrc = strobe.markerIn;
    end else if (g == HALF) begin : g_upperBottom
      assign upSrc = strobe.splitMode ? strobe.markerIn : stages[g-1];
    end else begin : g_upMid
      assign upSrc = stages[g-1];
    end

    assign nextStages[g] = strobe.towardFirst ? downSrc : upSrc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               stages <= '0;
    else if (strobe.shiftEn) stages <= nextStages;
  end

  // R1: no pulse, no change
  p_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.shiftEn |=> $stable(stages));

  // R2: full chain toward stage 1
  p_full_down_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shiftEn && !strobe.splitMode && strobe.towardFirst) |=>
      (stages[NUM_STAGES-1] == $past(strobe.markerIn)) &&
      (stages[NUM_STAGES-2:0] == $past(stages[NUM_STAGES-1:1])));

  // R3: full chain toward the last stage
  p_full_up_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shiftEn && !strobe.splitMode && !strobe.towardFirst) |=>
      (stages[0] == $past(strobe.markerIn)) &&
      (stages[NUM_STAGES-1:1] == $past(stages[NUM_STAGES-2:0])));

  // R4: split chains toward their low ends
  p_split_down_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shiftEn && strobe.splitMode && strobe.towardFirst) |=>
      (stages[HALF-1] == $past(strobe.markerIn)) &&
      (stages[NUM_STAGES-1] == $past(strobe.markerIn)) &&
      (stages[HALF-2:0] == $past(stages[HALF-1:1])) &&
      (stages[NUM_STAGES-2:HALF] == $past(stages[NUM_STAGES-1:HALF+1])));

  // R5: split chains toward their high ends
  p_split_up_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.shiftEn && strobe.splitMode && !strobe.towardFirst) |=>
      (stages[0] == $past(strobe.markerIn)) &&
      (stages[HALF] == $past(strobe.markerIn)) &&
      (stages[HALF-1:1] == $past(stages[HALF-2:0])) &&
      (stages[NUM_STAGES-1:HALF+1] == $past(stages[NUM_STAGES-2:HALF])));

endmodule

// File: rtl/levelSelect.sv
module levelSelect
  import commonScanPkg::*;
(
  input  logic   stageBit,
  input  logic   acPhase,
  input  logic   dispOffN,
  output level_e level
);

  always_comb begin
    if (!dispOffN) begin
      level = LVL_V1;
    end else begin
      unique case ({stageBit, acPhase})
        2'b11:   level = LVL_V2;
        2'b01:   level = LVL_V6;
        2'b10:   level = LVL_V1;
        default: level = LVL_V5;
      endcase
    end
  end

endmodule

// File: rtl/commonScanDriver.sv
module commonScanDriver
  import commonScanPkg::*;
#(
  parameter int NUM_STAGES = 240
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    lineClk,
  input  logic                    marker,
  input  logic                    shiftDir,
  input  logic                    fullDuty,
  input  logic                    acPhase,
  input  logic                    dispOffN,
  output logic [2*NUM_STAGES-1:0] levelCodes
);

  localparam int CODE_W = 2;

  scanStrobe_t           strobe;
  logic [NUM_STAGES-1:0] stages;

  scanControl i_scanControl (
    .clk      (clk),
    .rstN     (rstN),
    .lineClk  (lineClk),
    .marker   (marker),
    .shiftDir (shiftDir),
    .fullDuty (fullDuty),
    .strobe   (strobe)
  );

  scanShiftReg #(.NUM_STAGES(NUM_STAGES)) i_scanShiftReg (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .stages (stages)
  );

  for (genvar g = 0; g < NUM_STAGES; g++) begin : g_sel
    level_e lvl;
    levelSelect i_levelSelect (
      .stageBit (stages[g]),
      .acPhase  (acPhase),
      .dispOffN (dispOffN),
      .level    (lvl)
    );
    assign levelCodes[CODE_W*g +: CODE_W] = lvl;
  end

  // R7: blanking pins every output to V1
  p_blank_r7: assert property (@(posedge clk) disable iff (!rstN)
    !dispOffN |-> (levelCodes == '0));

endmodule

// File: tb/test_commonScanDriver.sv
module test_commonScanDriver;

  localparam int N    = 240;
  localparam int HALF = N / 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineClk = 1'b0, marker = 1'b0, shiftDir = 1'b0, fullDuty = 1'b1;
  logic acPhase = 1'b0, dispOffN = 1'b1;
  logic [2*N-1:0] levelCodes;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 0;

  logic [N-1:0] model = '0;
  logic modelLineQ = 1'b0;
  string lastTag = "R8";

  always #2.5 clk = ~clk;

  commonScanDriver #(.NUM_STAGES(N)) i_commonScanDriver (
    .clk(clk), .rstN(rstN), .lineClk(lineClk), .marker(marker),
    .shiftDir(shiftDir), .fullDuty(fullDuty), .acPhase(acPhase),
    .dispOffN(dispOffN), .levelCodes(levelCodes)
  );

  function automatic logic [N-1:0] advance(logic [N-1:0] cur, logic mk,
                                           logic dir, logic full);
    if (full)
      return dir ? {mk, cur[N-1:1]} : {cur[N-2:0], mk};
    else
      return dir ? {mk, cur[N-1:HALF+1], mk, cur[HALF-1:1]}
                 : {cur[N-2:HALF], mk, cur[HALF-2:0], mk};
  endfunction

  function automatic logic [1:0] codeOf(logic b, logic m, logic off);
    if (!off) return 2'b00;
    if (b && m) return 2'b11;
    if (!b && m) return 2'b01;
    if (b && !m) return 2'b00;
    return 2'b10;
  endfunction

  function automatic logic [2*N-1:0] expectCodes(logic [N-1:0] st, logic m, logic off);
    logic [2*N-1:0] v;
    for (int i = 0; i < N; i++) v[2*i +: 2] = codeOf(st[i], m, off);
    return v;
  endfunction

  function automatic string tagFor(logic fall, logic dir, logic full, logic off);
    if (!off) return "R7";
    if (!fall) return "R1";
    if (full) return dir ? "R2" : "R3";
    return dir ? "R4" : "R5";
  endfunction

  task automatic checkNow();
    logic [2*N-1:0] exp;
    exp = expectCodes(model, acPhase, dispOffN);
    checkCount++;
    if (levelCodes !== exp) begin
      failCount++;
      $display("FAIL %s: levelCodes actual=%h expected=%h", lastTag, levelCodes, exp);
    end
  endtask

  // Check the state produced by the previous step, then drive new inputs
  task automatic step(logic lc, logic mk, logic dir, logic full,
                      logic m, logic off, string tag);
    @(negedge clk);
    checkNow();
    lineClk = lc; marker = mk; shiftDir = dir; fullDuty = full;
    acPhase = m; dispOffN = off;
    if (modelLineQ && !lc) model = advance(model, mk, dir, full);
    modelLineQ = lc;
    lastTag = tag;
  endtask

  task automatic pulse(logic mk, logic dir, logic full, logic m, logic off, string tag);
    step(1'b1, mk, dir, full, m, off, "R1");
    step(1'b0, mk, dir, full, m, off, tag);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    lineClk = 1'b0;
    model = '0;
    modelLineQ = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    lastTag = "R8";
  endtask

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    int seedVal;
    logic lc, mk, dir, full, m, off, prevLc;
    seedVal = $urandom(32'h1d5e);

    // R8: reset state under both AC phases
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R8");
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R8");

    // R2: single marker walking toward stage 1, then a pattern
    pulse(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R2");
    for (int i = 0; i < 6; i++) pulse(i[0], 1'b1, 1'b1, 1'b1, 1'b1, "R2");

    // R1: inputs move with the line clock held high or low
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R1");
    for (int i = 0; i < 4; i++) step(1'b1, ~i[0], i[1], i[0], 1'b0, 1'b1, "R1");
    step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R1");
    for (int i = 0; i < 4; i++) step(1'b0, i[0], i[1], ~i[0], 1'b1, 1'b1, "R1");

    // R3: full chain toward the last stage, walked past the far end
    doReset();
    pulse(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R3");
    for (int i = 0; i < N + 2; i++) pulse(1'b0, 1'b0, 1'b1, i[0], 1'b1, "R3");

    // R4: split chains toward their low ends, across the half boundary
    doReset();
    pulse(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R4");
    for (int i = 0; i < HALF + 2; i++) pulse(i[2], 1'b1, 1'b0, 1'b0, 1'b1, "R4");

    // R5: split chains toward their high ends
    doReset();
    pulse(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R5");
    for (int i = 0; i < HALF + 2; i++) pulse(i[1], 1'b0, 1'b0, 1'b1, 1'b1, "R5");

    // R6: every data/phase combination with a mixed pattern held still
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 1'b0, i[0], 1'b1, "R6");

    // R7: blank while shifting, then show that shifting continued
    for (int i = 0; i < 5; i++) pulse(1'b1, 1'b1, 1'b1, i[0], 1'b0, "R7");
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R7");
    step(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, "R7");

    // Random mix of all inputs, including mid-frame duty changes
    prevLc = lineClk;
    for (int i = 0; i < 6000; i++) begin
      lc   = ($urandom % 3 == 0) ? ~prevLc : prevLc;
      mk   = ($urandom % 4 == 0);
      dir  = ($urandom % 8 == 0) ? ~shiftDir : shiftDir;
      full = ($urandom % 16 == 0) ? ~fullDuty : fullDuty;
      m    = ($urandom % 5 == 0) ? ~acPhase : acPhase;
      off  = ($urandom % 10 != 0);
      step(lc, mk, dir, full, m, off, tagFor(prevLc && !lc, dir, full, off));
      prevLc = lc;
    end

    @(negedge clk);
    checkNow();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule